// File: doc/BRIEF.md
# Receive Buffer Resource Ring Manager

This block keeps track of where incoming frames may be stored. Software places a circular table of buffer descriptors in memory; each descriptor gives a 32-bit buffer base address and a 32-bit size in 16-bit words. The block holds four ring pointers (start, end, read and write), fetches one descriptor at a time over a simple 16-bit read port, and presents the current buffer address and remaining word count to the receive datapath. It advances the read pointer past each fetched descriptor and wraps it back to the start when it reaches the end. It raises an interrupt flag when the read pointer catches up with the write pointer that software maintains.

For every frame the receive side reports its byte length. The block rounds the length, with its four CRC bytes, up to the bus granule. It then either stores the frame, moving the buffer address forward and reducing the count, or drops it because it does not fit. A frame that leaves the buffer below a programmable threshold, or that does not fit at all, marks the buffer as finished. The block then fetches the next descriptor by itself, or enters a stalled state when the ring has no descriptor left. In the stalled state every frame is refused until a descriptor fetch completes.

Top module: `rx_rsrc_ring`

## Requirements
- R1: After synchronous reset, busy, all flags, the buffer address, the word count and all pointers are zero, and the end-of-buffer threshold is 0x02F8.
- R2: A register write (reg_sel 0 = ring start, 1 = ring end, 2 = read pointer, 3 = write pointer, 4 = threshold) stores a pointer with bits [1:0] cleared when cfg_wide is 1 and with bit 0 cleared when cfg_wide is 0. The threshold is stored unmasked.
- R3: A fetch begins on a one-cycle fetch_cmd pulse. busy is high from the next cycle until the fourth word is returned. Word k (k = 0..3) is read at rd_ptr + 2k in 16-bit mode or rd_ptr + 4k in 32-bit mode, in the order address low, address high, count low, count high. When busy falls, buf_addr and buf_words hold the fetched values.
- R4: Each completed fetch advances rd_ptr by 8 (16-bit mode) or 16 (32-bit mode). If the result equals the ring end pointer, rd_ptr becomes the ring start pointer instead.
- R5: irq_rsrc_exh sets when rd_ptr equals the write pointer after a fetch's advance and wrap.
- R6: A clr_rsrc_exh pulse while irq_rsrc_exh is set clears it and starts a fetch. While the flag is clear, the pulse has no effect.
- R7: The padded length is frm_len + 4 rounded up to a multiple of 4 (32-bit mode) or 2 (16-bit mode). An accepted frame pulses frm_ok one cycle after frm_valid, adds the padded length to buf_addr and subtracts half of it from buf_words.
- R8: If the padded length exceeds twice buf_words, the frame is dropped (frm_drop) with address and count unchanged, and irq_buf_exh and last_pkt set. A clr_buf_exh pulse clears irq_buf_exh.
- R9: last_pkt shows the outcome of the latest frame. After a store it is 1 exactly when the new word count is below the threshold.
- R10: When a frame sets last_pkt, a fetch starts the next cycle if rd_ptr differs from the write pointer; otherwise rx_stall sets.
- R11: While rx_stall is set, frames are dropped, last_pkt clears and the address and count are unchanged. rx_stall clears only when a fetch completes.
- R12: A frame offered while busy is high is dropped and changes neither the buffer state nor last_pkt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 selects 32-bit descriptor layout, 0 selects 16-bit |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 start, 1 end, 2 read, 3 write, 4 threshold |
| reg_wdata | input | 16 | Register write data |
| fetch_cmd | input | 1 | One-cycle request to fetch a descriptor |
| clr_rsrc_exh | input | 1 | Write-one clear of irq_rsrc_exh, which also starts a fetch |
| clr_buf_exh | input | 1 | Write-one clear of irq_buf_exh |
| frm_valid | input | 1 | Frame length offered this cycle |
| frm_len | input | 16 | Frame length in bytes, without CRC |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_rvalid | input | 1 | Requested word is on mem_rdata |
| mem_rdata | input | 16 | Returned descriptor word |
| busy | output | 1 | Descriptor fetch in progress |
| buf_addr | output | 32 | Current buffer write address |
| buf_words | output | 32 | Remaining buffer size in 16-bit words |
| rd_ptr | output | 16 | Ring read pointer |
| last_pkt | output | 1 | Latest frame finished the current buffer |
| irq_rsrc_exh | output | 1 | Ring out of descriptors |
| irq_buf_exh | output | 1 | A frame did not fit the current buffer |
| rx_stall | output | 1 | Reception blocked until the next fetch |
| frm_ok | output | 1 | Frame stored (one-cycle pulse) |
| frm_drop | output | 1 | Frame dropped (one-cycle pulse) |

## Verification
Frame results are due one cycle after frm_valid is sampled: frm_ok, frm_drop, last_pkt, irq_buf_exh, buf_addr and buf_words change at that edge. When a frame or command starts a fetch, busy is already high at the same point. The fetched address, count, advanced rd_ptr, irq_rsrc_exh and cleared rx_stall are due at the edge on which the fourth word is accepted, which is the edge at which busy falls. The memory responder answers after a random delay, so the bench drives each stimulus for one cycle, samples on the following falling edge, and then polls busy on falling edges before it compares fetch results with its model.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    localparam int PTR_W      = 16;
    localparam int HW_W       = 16;
    localparam int BUF_AW     = 2 * HW_W;
    localparam int CNT_W      = 2 * HW_W;
    localparam int LEN_W      = 16;
    localparam int DESC_WORDS = 4;
    localparam int RING_PTRS  = 4;
    localparam int SEL_W      = 3;
    localparam logic [HW_W-1:0] EOB_RESET = 16'h02F8;

    localparam logic [SEL_W-1:0] RSEL_START = 3'd0;
    localparam logic [SEL_W-1:0] RSEL_END   = 3'd1;
    localparam logic [SEL_W-1:0] RSEL_RD    = 3'd2;
    localparam logic [SEL_W-1:0] RSEL_WR    = 3'd3;
    localparam logic [SEL_W-1:0] RSEL_EOB   = 3'd4;

    typedef struct packed {
        logic [BUF_AW-1:0] base;
        logic [CNT_W-1:0]  words;
    } rsrc_desc_t;

    typedef enum logic [1:0] {
        V_STORE,
        V_OVERSIZE,
        V_STALLED,
        V_BUSY
    } verdict_e;

    function automatic logic [PTR_W-1:0] align_ptr(input logic [PTR_W-1:0] p,
                                                   input logic wide);
        return wide ? {p[PTR_W-1:2], 2'b00} : {p[PTR_W-1:1], 1'b0};
    endfunction

    function automatic logic [PTR_W-1:0] desc_bytes(input logic wide);
        return wide ? PTR_W'(16) : PTR_W'(8);
    endfunction

    function automatic logic [LEN_W:0] padded_len(input logic [LEN_W-1:0] len,
                                                  input logic wide);
        logic [LEN_W:0] raw;
        raw = {1'b0, len} + (LEN_W+1)'(3);
        if (wide) return (raw | (LEN_W+1)'(3)) + (LEN_W+1)'(1);
        return (raw | (LEN_W+1)'(1)) + (LEN_W+1)'(1);
    endfunction

endpackage

// File: rtl/rrm_ptr_regs.sv
module rrm_ptr_regs
    import rrm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wide,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [PTR_W-1:0] wdata,
    input  logic             advance,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             ring_dry,
    output logic             adv_hits_wr
);

    logic [PTR_W-1:0] ptr_q [RING_PTRS];
    logic [PTR_W-1:0] stepped;
    logic [PTR_W-1:0] next_rd;

    always_comb begin
        stepped     = ptr_q[RSEL_RD] + desc_bytes(wide);
        next_rd     = (stepped == ptr_q[RSEL_END]) ? ptr_q[RSEL_START] : stepped;
        adv_hits_wr = (next_rd == ptr_q[RSEL_WR]);
        ring_dry    = (ptr_q[RSEL_RD] == ptr_q[RSEL_WR]);
        rd_ptr      = ptr_q[RSEL_RD];
    end

    for (genvar g = 0; g < RING_PTRS; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[g] <= '0;
            end else if (advance && (SEL_W'(g) == RSEL_RD)) begin
                ptr_q[g] <= next_rd;
            end else if (wr_en && (sel == SEL_W'(g))) begin
                ptr_q[g] <= align_ptr(wdata, wide);
            end
        end
    end

endmodule

// File: rtl/rrm_fetch.sv
module rrm_fetch
    import rrm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             wide,
    input  logic [PTR_W-1:0] base,
    input  logic             mem_rvalid,
    input  logic [HW_W-1:0]  mem_rdata,
    output logic             busy,
    output logic             mem_req,
    output logic [PTR_W-1:0] mem_addr,
    output logic             done,
    output rsrc_desc_t       desc
);

    localparam int IDX_W = $clog2(DESC_WORDS);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [HW_W-1:0]  word_q [DESC_WORDS-1];

    always_comb begin
        busy       = busy_q;
        mem_req    = busy_q;
        mem_addr   = base + (PTR_W'(idx_q) << (wide ? 2 : 1));
        done       = busy_q && mem_rvalid && (idx_q == IDX_W'(DESC_WORDS - 1));
        desc.base  = {word_q[1], word_q[0]};
        desc.words = {mem_rdata, word_q[2]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
            end
        end else if (mem_rvalid) begin
            if (done) busy_q <= 1'b0;
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    for (genvar k = 0; k < DESC_WORDS - 1; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[k] <= '0;
            end else if (busy_q && mem_rvalid && (idx_q == IDX_W'(k))) begin
                word_q[k] <= mem_rdata;
            end
        end
    end

endmodule

// File: rtl/rrm_buf_track.sv
module rrm_buf_track
    import rrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              eob_wr,
    input  logic [HW_W-1:0]   eob_wdata,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              busy,
    input  logic              stall,
    input  logic              load,
    input  rsrc_desc_t        load_desc,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [CNT_W-1:0]  buf_words,
    output logic              frm_ok,
    output logic              frm_drop,
    output logic              last_pkt,
    output logic              oversize_evt,
    output logic              last_evt
);

    logic [BUF_AW-1:0] addr_q;
    logic [CNT_W-1:0]  words_q;
    logic [HW_W-1:0]   eob_q;
    logic              ok_q, drop_q, last_q;

    logic [LEN_W:0]    pad;
    logic              too_big;
    logic [CNT_W-1:0]  words_after;
    logic              low_after;
    verdict_e          verdict;

    always_comb begin
        pad         = padded_len(frm_len, wide);
        too_big     = (CNT_W+1)'(pad) > {words_q, 1'b0};
        words_after = words_q - CNT_W'(pad >> 1);
        low_after   = words_after < CNT_W'(eob_q);
        if (busy)         verdict = V_BUSY;
        else if (stall)   verdict = V_STALLED;
        else if (too_big) verdict = V_OVERSIZE;
        else              verdict = V_STORE;
        oversize_evt = frm_valid && (verdict == V_OVERSIZE);
        last_evt     = frm_valid && ((verdict == V_OVERSIZE) ||
                                     ((verdict == V_STORE) && low_after));
        buf_addr  = addr_q;
        buf_words = words_q;
        frm_ok    = ok_q;
        frm_drop  = drop_q;
        last_pkt  = last_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            words_q <= '0;
            eob_q   <= EOB_RESET;
            ok_q    <= 1'b0;
            drop_q  <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            ok_q   <= 1'b0;
            drop_q <= 1'b0;
            if (eob_wr) eob_q <= eob_wdata;
            if (load) begin
                addr_q  <= load_desc.base;
                words_q <= load_desc.words;
            end else if (frm_valid && (verdict == V_STORE)) begin
                addr_q  <= addr_q + BUF_AW'(pad);
                words_q <= words_after;
            end
            if (frm_valid) begin
                case (verdict)
                    V_STORE: begin
                        ok_q   <= 1'b1;
                        last_q <= low_after;
                    end
                    V_OVERSIZE: begin
                        drop_q <= 1'b1;
                        last_q <= 1'b1;
                    end
                    V_STALLED: begin
                        drop_q <= 1'b1;
                        last_q <= 1'b0;
                    end
                    default: drop_q <= 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_rsrc_ring.sv
module rx_rsrc_ring
    import rrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic              reg_wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [HW_W-1:0]   reg_wdata,
    input  logic              fetch_cmd,
    input  logic              clr_rsrc_exh,
    input  logic              clr_buf_exh,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic              mem_rvalid,
    input  logic [HW_W-1:0]   mem_rdata,
    output logic              busy,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [CNT_W-1:0]  buf_words,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              last_pkt,
    output logic              irq_rsrc_exh,
    output logic              irq_buf_exh,
    output logic              rx_stall,
    output logic              frm_ok,
    output logic              frm_drop
);

    logic       ring_dry, adv_hits_wr;
    logic       fetch_done, start_fetch;
    logic       oversize_evt, last_evt;
    logic       stall_q, rexh_q, bexh_q;
    rsrc_desc_t fetched;

    always_comb begin
        start_fetch = !busy && (fetch_cmd ||
                                (clr_rsrc_exh && rexh_q) ||
                                (last_evt && !ring_dry));
        rx_stall     = stall_q;
        irq_rsrc_exh = rexh_q;
        irq_buf_exh  = bexh_q;
    end

    rrm_ptr_regs u_ptrs (
        .clk         (clk),
        .rst         (rst),
        .wide        (cfg_wide),
        .wr_en       (reg_wr_en),
        .sel         (reg_sel),
        .wdata       (reg_wdata),
        .advance     (fetch_done),
        .rd_ptr      (rd_ptr),
        .ring_dry    (ring_dry),
        .adv_hits_wr (adv_hits_wr)
    );

    rrm_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (start_fetch),
        .wide       (cfg_wide),
        .base       (rd_ptr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .done       (fetch_done),
        .desc       (fetched)
    );

    rrm_buf_track u_track (
        .clk          (clk),
        .rst          (rst),
        .wide         (cfg_wide),
        .eob_wr       (reg_wr_en && (reg_sel == RSEL_EOB)),
        .eob_wdata    (reg_wdata),
        .frm_valid    (frm_valid),
        .frm_len      (frm_len),
        .busy         (busy),
        .stall        (stall_q),
        .load         (fetch_done),
        .load_desc    (fetched),
        .buf_addr     (buf_addr),
        .buf_words    (buf_words),
        .frm_ok       (frm_ok),
        .frm_drop     (frm_drop),
        .last_pkt     (last_pkt),
        .oversize_evt (oversize_evt),
        .last_evt     (last_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= 1'b0;
            rexh_q  <= 1'b0;
            bexh_q  <= 1'b0;
        end else begin
            if (fetch_done)                 stall_q <= 1'b0;
            else if (last_evt && ring_dry)  stall_q <= 1'b1;

            if (fetch_done && adv_hits_wr)  rexh_q <= 1'b1;
            else if (clr_rsrc_exh)          rexh_q <= 1'b0;

            if (oversize_evt)               bexh_q <= 1'b1;
            else if (clr_buf_exh)           bexh_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_rsrc_ring_chk.sv
module rx_rsrc_ring_chk (
    input logic        clk,
    input logic        rst,
    input logic        fetch_cmd,
    input logic        clr_rsrc_exh,
    input logic        frm_valid,
    input logic        busy,
    input logic        rx_stall,
    input logic        frm_ok,
    input logic        frm_drop,
    input logic        last_pkt,
    input logic [31:0] buf_words,
    input logic [15:0] rd_ptr
);

    // R3: a fetch only starts after one of its triggers
    a_r3_busy_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(fetch_cmd || clr_rsrc_exh || frm_valid));

    // R4: the read pointer is always at least halfword aligned
    a_r4_rdptr_even: assert property (@(posedge clk) disable iff (rst)
        rd_ptr[0] == 1'b0);

    // R7: a frame is never both stored and dropped
    a_r7_ok_drop_excl: assert property (@(posedge clk) disable iff (rst)
        !(frm_ok && frm_drop));

    // R8: a dropped frame leaves the word count untouched
    a_r8_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
        frm_drop |-> $stable(buf_words));

    // R11: frames offered while stalled are refused and clear last_pkt
    a_r11_stall_drops: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && rx_stall && !busy) |=> (frm_drop && !last_pkt));

    // R11: a completed fetch leaves the stall state
    a_r11_fetch_ends_stall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !rx_stall);

    // R12: frames offered during a fetch are refused
    a_r12_busy_drop: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && busy) |=> frm_drop);

endmodule

bind rx_rsrc_ring rx_rsrc_ring_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .fetch_cmd    (fetch_cmd),
    .clr_rsrc_exh (clr_rsrc_exh),
    .frm_valid    (frm_valid),
    .busy         (busy),
    .rx_stall     (rx_stall),
    .frm_ok       (frm_ok),
    .frm_drop     (frm_drop),
    .last_pkt     (last_pkt),
    .buf_words    (buf_words),
    .rd_ptr       (rd_ptr)
);

// File: tb/rx_rsrc_ring_tb_top.sv
module rx_rsrc_ring_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wide = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        fetch_cmd = 1'b0;
    logic        clr_rsrc_exh = 1'b0;
    logic        clr_buf_exh = 1'b0;
    logic        frm_valid = 1'b0;
    logic [15:0] frm_len = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        busy;
    logic [31:0] buf_addr, buf_words;
    logic [15:0] rd_ptr;
    logic        last_pkt, irq_rsrc_exh, irq_buf_exh, rx_stall, frm_ok, frm_drop;

    always #10 clk = ~clk;

    rx_rsrc_ring dut_i (.*);

    logic [15:0] mem [256];

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // bench model state
    logic [15:0] e_ptr [4];
    logic [15:0] e_eob;
    logic [31:0] e_addr, e_words;
    bit e_wide, e_stall, e_rexh, e_bexh, e_last;

    initial begin
        mem_rvalid = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) mem_rvalid = 1'b0;
            else if (mem_req && ($urandom % 3) != 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[mem_addr[8:1]];
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] f_align(input logic [15:0] p, input bit w);
        return w ? {p[15:2], 2'b00} : {p[15:1], 1'b0};
    endfunction

    function automatic logic [16:0] f_pad(input int len, input bit w);
        int r;
        r = len + 4;
        if (w) r = (r + 3) / 4 * 4;
        else   r = (r + 1) / 2 * 2;
        return 17'(r);
    endfunction

    task automatic put_desc(input logic [15:0] at, input bit w,
                            input logic [31:0] a, input logic [31:0] n);
        logic [15:0] s;
        s = w ? 16'd4 : 16'd2;
        mem[8'((at) >> 1)]         = a[15:0];
        mem[8'((at + s) >> 1)]     = a[31:16];
        mem[8'((at + 2 * s) >> 1)] = n[15:0];
        mem[8'((at + 3 * s) >> 1)] = n[31:16];
    endtask

    task automatic wait_idle;
        while (busy) @(negedge clk);
    endtask

    task automatic m_fetch;
        logic [15:0] s, w0, w1, w2, w3, nx;
        s  = e_wide ? 16'd4 : 16'd2;
        w0 = mem[8'((e_ptr[2]) >> 1)];
        w1 = mem[8'((e_ptr[2] + s) >> 1)];
        w2 = mem[8'((e_ptr[2] + 2 * s) >> 1)];
        w3 = mem[8'((e_ptr[2] + 3 * s) >> 1)];
        e_addr  = {w1, w0};
        e_words = {w3, w2};
        nx = e_ptr[2] + (e_wide ? 16'd16 : 16'd8);
        if (nx == e_ptr[1]) nx = e_ptr[0];
        e_ptr[2] = nx;
        if (nx == e_ptr[3]) e_rexh = 1'b1;
        e_stall = 1'b0;
    endtask

    task automatic chk_fetch;
        chk("R3 buf_addr", buf_addr, e_addr);
        chk("R3 buf_words", buf_words, e_words);
        chk("R4 rd_ptr", 32'(rd_ptr), 32'(e_ptr[2]));
        chk("R5 irq_rsrc_exh", 32'(irq_rsrc_exh), 32'(e_rexh));
        chk("R11 stall after fetch", 32'(rx_stall), 32'(e_stall));
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [15:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (sel < 3'd4) e_ptr[sel[1:0]] = f_align(val, e_wide);
        else e_eob = val;
    endtask

    task automatic cmd_fetch;
        @(negedge clk) fetch_cmd = 1'b1;
        @(negedge clk) fetch_cmd = 1'b0;
        chk("R3 busy after cmd", 32'(busy), 32'd1);
        wait_idle();
        m_fetch();
        chk_fetch();
    endtask

    task automatic clr_rexh;
        @(negedge clk) clr_rsrc_exh = 1'b1;
        @(negedge clk) clr_rsrc_exh = 1'b0;
        if (e_rexh) begin
            e_rexh = 1'b0;
            chk("R6 clear starts fetch", 32'(busy), 32'd1);
            wait_idle();
            m_fetch();
            chk_fetch();
        end else begin
            chk("R6 clear when idle no fetch", 32'(busy), 32'd0);
            chk("R6 flag stays clear", 32'(irq_rsrc_exh), 32'd0);
        end
    endtask

    task automatic clr_bexh;
        @(negedge clk) clr_buf_exh = 1'b1;
        @(negedge clk) clr_buf_exh = 1'b0;
        e_bexh = 1'b0;
        chk("R8 buf_exh cleared", 32'(irq_buf_exh), 32'd0);
    endtask

    task automatic send_frame(input int len);
        logic [16:0] pad;
        bit exp_ok, exp_fetch;
        @(negedge clk);
        frm_valid = 1'b1; frm_len = 16'(len);
        @(negedge clk);
        frm_valid = 1'b0;
        pad = f_pad(len, e_wide);
        exp_fetch = 1'b0;
        if (e_stall) begin
            exp_ok = 1'b0;
            e_last = 1'b0;
        end else begin
            if (33'(pad) > {e_words, 1'b0}) begin
                exp_ok = 1'b0; e_bexh = 1'b1; e_last = 1'b1;
            end else begin
                exp_ok  = 1'b1;
                e_addr  = e_addr + 32'(pad);
                e_words = e_words - 32'(pad >> 1);
                e_last  = e_words < 32'(e_eob);
            end
            if (e_last) begin
                if (e_ptr[2] != e_ptr[3]) exp_fetch = 1'b1;
                else e_stall = 1'b1;
            end
        end
        chk("R7 frm_ok", 32'(frm_ok), 32'(exp_ok));
        chk("R8 frm_drop", 32'(frm_drop), 32'(!exp_ok));
        chk("R9 last_pkt", 32'(last_pkt), 32'(e_last));
        chk("R8 irq_buf_exh", 32'(irq_buf_exh), 32'(e_bexh));
        chk("R10 auto fetch", 32'(busy), 32'(exp_fetch));
        if (exp_fetch) begin
            wait_idle();
            m_fetch();
            chk_fetch();
        end else begin
            chk("R7 buf_addr", buf_addr, e_addr);
            chk("R7 buf_words", buf_words, e_words);
            chk("R11 rx_stall", 32'(rx_stall), 32'(e_stall));
        end
    endtask

    task automatic busy_frame;
        bit prev_last;
        prev_last = e_last;
        @(negedge clk) fetch_cmd = 1'b1;
        @(negedge clk) begin
            fetch_cmd = 1'b0;
            frm_valid = 1'b1;
            frm_len   = 16'd60;
        end
        @(negedge clk) frm_valid = 1'b0;
        chk("R12 drop while busy", 32'(frm_drop), 32'd1);
        chk("R12 last_pkt kept", 32'(last_pkt), 32'(prev_last));
        wait_idle();
        m_fetch();
        chk_fetch();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7);
        for (int i = 0; i < 4; i++) e_ptr[i] = '0;
        e_eob = 16'h02F8; e_addr = '0; e_words = '0;
        e_wide = 1'b0; e_stall = 1'b0; e_rexh = 1'b0; e_bexh = 1'b0; e_last = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 buf_addr", buf_addr, 32'd0);
        chk("R1 buf_words", buf_words, 32'd0);
        chk("R1 rd_ptr", 32'(rd_ptr), 32'd0);
        chk("R1 flags", {26'd0, last_pkt, irq_rsrc_exh, irq_buf_exh, rx_stall, frm_ok, frm_drop}, 32'd0);

        // R2 alignment in both modes
        wr_reg(3'd2, 16'h0043);
        chk("R2 narrow align", 32'(rd_ptr), 32'h0042);
        @(negedge clk) cfg_wide = 1'b1; e_wide = 1'b1;
        wr_reg(3'd2, 16'h0043);
        chk("R2 wide align", 32'(rd_ptr), 32'h0040);
        @(negedge clk) cfg_wide = 1'b0; e_wide = 1'b0;

        // directed ring in 16-bit mode: start 0x40, end 0x58, write 0x50
        put_desc(16'h0040, 1'b0, 32'h0001_1000, 32'd1024);
        put_desc(16'h0048, 1'b0, 32'h0002_2000, 32'd800);
        put_desc(16'h0050, 1'b0, 32'h0003_0000, 32'd16);
        wr_reg(3'd0, 16'h0041);
        wr_reg(3'd1, 16'h0058);
        wr_reg(3'd2, 16'h0040);
        wr_reg(3'd3, 16'h0050);

        cmd_fetch();          // R3/R4: rd 0x48
        send_frame(60);       // R7 pad 64
        send_frame(61);       // R7 pad 66
        send_frame(400);      // R9/R1: 757 < 0x2F8, R10 auto fetch, R5 rd==wr
        send_frame(1600);     // R8 oversize, R10 ring dry -> stall
        send_frame(60);       // R11 dropped while stalled
        clr_bexh();           // R8
        clr_rexh();           // R6 + R4 wrap to 0x40
        send_frame(60);       // R8 oversize on 16-word buffer, auto fetch
        clr_rexh();           // R6 no effect while clear
        busy_frame();         // R12

        // random phase in 32-bit mode
        @(negedge clk) cfg_wide = 1'b1; e_wide = 1'b1;
        for (int d = 0; d < 4; d++)
            put_desc(16'(16'h0080 + 16 * d), 1'b1, $urandom, 32'(150 + $urandom % 1050));
        wr_reg(3'd0, 16'h0081);
        wr_reg(3'd1, 16'h00C2);
        wr_reg(3'd2, 16'h0080);
        wr_reg(3'd3, 16'h00B3);
        cmd_fetch();
        for (int it = 0; it < 400; it++) begin
            int act;
            act = int'($urandom % 20);
            if (act < 14) send_frame(int'(40 + $urandom % 1560));
            else if (act == 14) cmd_fetch();
            else if (act == 15) clr_rexh();
            else if (act == 16) clr_bexh();
            else if (act == 17) wr_reg(3'd4, 16'(100 + $urandom % 800));
            else begin
                wr_reg(3'd3, 16'(16'h0080 + 16 * ($urandom % 4) + ($urandom % 4)));
                for (int d = 0; d < 4; d++)
                    put_desc(16'(16'h0080 + 16 * d), 1'b1, $urandom, 32'(150 + $urandom % 1050));
            end
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule